// File: doc/BRIEF.md
# Byte-Wide Flash Write and Erase Sequencer

This block sits on the host side of an asynchronous, byte-wide flash bus. A client asks for one operation at a time: a byte program (address and data), a sector erase (any address inside the sector), or a whole-chip erase. The sequencer generates the unlock and command write cycles itself. It derives every strobe width from nanosecond parameters and the clock period, rounding up so that no minimum is violated. It then reads the device repeatedly until the operation is seen to be complete, and signals the end with a one-cycle done pulse and an error flag.

Completion is detected by one of two status methods, selected per request. The toggle method compares bit 6 between consecutive reads. The data method compares bit 7 with the value expected once the operation ends. In both methods a read that looks complete must be backed by further agreeing reads before it is trusted. A timeout counter sized from the worst-case time of each operation ends a hung operation with the error flag.

Top module: `nvm_write_seq`

## Requirements
- R1: Out of reset and whenever no operation is running, the chip-enable, output-enable and write-enable strobes are high, the data bus is not driven, and busy is low.
- R2: A request is taken only when the block is idle and not signalling done, with req_op encoded 1 = byte program, 2 = sector erase, 3 = chip erase. A request with req_op = 0, or any request made while busy, has no effect: it adds no bus cycles and does not change the operation in progress.
- R3: A byte program issues exactly four writes (address/data): 555h/AAh, 2AAh/55h, 555h/A0h, then the target address with the request data.
- R4: An erase issues exactly six writes: 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h. The sixth is 555h/10h for chip erase. For sector erase it is 20h at the request address with its low log2(SECT_BYTES) bits cleared (sectors of 128 bytes by default).
- R5: Each write-enable low pulse lasts at least ceil(T_WP_NS/CLK_NS) cycles, and each high gap between writes at least ceil(T_WPH_NS/CLK_NS) cycles. Address and data are driven and stable for the whole low pulse and are still driven when write-enable rises.
- R6: Output-enable is never low while write-enable is low, and the data bus is never driven while output-enable is low. Output-enable stays high for at least ceil(T_OEH_NS/CLK_NS) cycles after a write ends before a status read begins.
- R7: In toggle mode (req_poll_mode = 0), a read is counted as good when its bit 6 equals bit 6 of the previous read. Done comes after CONFIRM_READS+1 good reads in a row (three by default).
- R8: In data mode (req_poll_mode = 1), a read is counted as good when bit 7 equals the request data bit 7 for a program, or 1 for an erase. Done comes after CONFIRM_READS+1 good reads in a row. A bad read between them restarts the count.
- R9: If polling lasts longer than the operation's limit, the operation ends with done and err both high. The limits are ceil(max_us*1000*TO_SCALE/CLK_NS) cycles, with max_us = 20 for a program, 25000 for a sector erase and 100000 for a chip erase. Err is never high without done.
- R10: Busy rises on the clock after a request is taken and stays high until the operation ends. It then falls in the same cycle that done pulses high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Operation code (1 program, 2 sector erase, 3 chip erase) |
| req_addr | input | ADDR_W | Target byte address or any address in the sector |
| req_data | input | 8 | Byte to program |
| req_poll_mode | input | 1 | 0 toggle-bit detection, 1 data-bit detection |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Operation ended by timeout (valid with done) |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_dq_out | output | 8 | Flash data to write |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_out |
| fl_dq_in | input | 8 | Flash data read back |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |

## Verification
The properties assume that fl_dq_in is stable while output-enable is low, and that req_op carries only the four listed codes. The bench's device model changes its status only on the rising edge of output-enable, so each read sees one settled value. The model answers with a fixed number of busy reads, alternating bit 6 and complementing bit 7. It can also return one misleading "complete" value inside the busy window, which exercises the restart of the confirmation count. Requests are driven on the falling clock edge, and no request is issued during the done cycle except where a test checks that it is ignored.

// File: rtl/nws_pkg.sv
package nws_pkg;

    localparam int BYTE_W = 8;

    localparam logic [14:0] UNLOCK_ADDR_A = 15'h555;
    localparam logic [14:0] UNLOCK_ADDR_B = 15'h2AA;
    localparam logic [7:0]  KEY_A         = 8'hAA;
    localparam logic [7:0]  KEY_B         = 8'h55;
    localparam logic [7:0]  CODE_PROGRAM  = 8'hA0;
    localparam logic [7:0]  CODE_ERASE    = 8'h80;
    localparam logic [7:0]  CODE_CHIP     = 8'h10;
    localparam logic [7:0]  CODE_SECTOR   = 8'h20;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PROG = 2'd1,
        OP_SECT = 2'd2,
        OP_CHIP = 2'd3
    } op_e;

    typedef enum logic {
        PM_TOGGLE = 1'b0,
        PM_DATA   = 1'b1
    } pmode_e;

    typedef enum logic [1:0] {
        AK_UNLOCK_A,
        AK_UNLOCK_B,
        AK_TARGET,
        AK_SECTOR
    } akind_e;

    typedef struct packed {
        akind_e             ak;
        logic               use_data;
        logic [BYTE_W-1:0]  code;
    } slot_t;

    function automatic longint unsigned cdiv(input longint unsigned a, input longint unsigned b);
        return (a + b - 1) / b;
    endfunction

    function automatic longint unsigned lmax(input longint unsigned a, input longint unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Which address kind and code each step of a command uses.
    function automatic slot_t cmd_slot(input op_e op, input logic [2:0] idx);
        slot_t s;
        s = '{ak: AK_UNLOCK_A, use_data: 1'b0, code: KEY_A};
        case (idx)
            3'd0: s = '{ak: AK_UNLOCK_A, use_data: 1'b0, code: KEY_A};
            3'd1: s = '{ak: AK_UNLOCK_B, use_data: 1'b0, code: KEY_B};
            3'd2: s = '{ak: AK_UNLOCK_A, use_data: 1'b0,
                        code: (op == OP_PROG) ? CODE_PROGRAM : CODE_ERASE};
            3'd3: begin
                if (op == OP_PROG) s = '{ak: AK_TARGET, use_data: 1'b1, code: 8'h00};
                else               s = '{ak: AK_UNLOCK_A, use_data: 1'b0, code: KEY_A};
            end
            3'd4: s = '{ak: AK_UNLOCK_B, use_data: 1'b0, code: KEY_B};
            default: begin
                if (op == OP_CHIP) s = '{ak: AK_UNLOCK_A, use_data: 1'b0, code: CODE_CHIP};
                else               s = '{ak: AK_SECTOR, use_data: 1'b0, code: CODE_SECTOR};
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/nws_bus.sv
module nws_bus
    import nws_pkg::*;
#(
    parameter int ADDR_W  = 19,
    parameter int WP_CYC  = 10,
    parameter int WPH_CYC = 8,
    parameter int OEH_CYC = 3,
    parameter int ACC_CYC = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_wr,
    input  logic              start_rd,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [BYTE_W-1:0] data_in,
    input  logic [BYTE_W-1:0] dq_in,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] rdata,
    output logic [ADDR_W-1:0] f_addr,
    output logic [BYTE_W-1:0] f_dout,
    output logic              f_doe,
    output logic              f_ce_n,
    output logic              f_oe_n,
    output logic              f_we_n
);

    localparam longint unsigned CMAX =
        lmax(lmax(64'(WP_CYC), 64'(WPH_CYC)), lmax(64'(OEH_CYC), 64'(ACC_CYC)));
    localparam int CNT_W = $clog2(int'(CMAX) + 1);

    typedef enum logic [2:0] {
        B_IDLE, B_WSET, B_WLOW, B_WHIGH, B_RGAP, B_RLOW
    } bst_e;

    bst_e             bs;
    logic [CNT_W-1:0] cnt;

    assign busy = (bs != B_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            bs     <= B_IDLE;
            cnt    <= '0;
            done   <= 1'b0;
            rdata  <= '0;
            f_addr <= '0;
            f_dout <= '0;
            f_doe  <= 1'b0;
            f_ce_n <= 1'b1;
            f_oe_n <= 1'b1;
            f_we_n <= 1'b1;
        end else begin
            done <= 1'b0;
            case (bs)
                B_IDLE: begin
                    if (start_wr) begin
                        f_addr <= addr_in;
                        f_dout <= data_in;
                        f_doe  <= 1'b1;
                        f_ce_n <= 1'b0;
                        bs     <= B_WSET;
                    end else if (start_rd) begin
                        f_addr <= addr_in;
                        f_ce_n <= 1'b0;
                        cnt    <= CNT_W'(OEH_CYC - 1);
                        bs     <= B_RGAP;
                    end
                end
                B_WSET: begin
                    f_we_n <= 1'b0;
                    cnt    <= CNT_W'(WP_CYC - 1);
                    bs     <= B_WLOW;
                end
                B_WLOW: begin
                    if (cnt == '0) begin
                        f_we_n <= 1'b1;
                        cnt    <= CNT_W'(WPH_CYC - 1);
                        bs     <= B_WHIGH;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                B_WHIGH: begin
                    if (cnt == '0) begin
                        f_doe  <= 1'b0;
                        f_ce_n <= 1'b1;
                        done   <= 1'b1;
                        bs     <= B_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                B_RGAP: begin
                    if (cnt == '0) begin
                        f_oe_n <= 1'b0;
                        cnt    <= CNT_W'(ACC_CYC - 1);
                        bs     <= B_RLOW;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                B_RLOW: begin
                    if (cnt == '0) begin
                        rdata  <= dq_in;
                        f_oe_n <= 1'b1;
                        f_ce_n <= 1'b1;
                        done   <= 1'b1;
                        bs     <= B_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: bs <= B_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nws_poll.sv
module nws_poll
    import nws_pkg::*;
#(
    parameter int CONFIRM_READS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              rd_valid,
    input  logic [BYTE_W-1:0] rd_data,
    input  pmode_e            mode,
    input  logic              exp7,
    output logic              complete
);

    localparam int TGT = CONFIRM_READS + 1;
    localparam int HW  = $clog2(TGT + 1);

    logic          have_prev;
    logic          prev6;
    logic [HW-1:0] hits;
    logic          good;

    always_comb begin
        if (mode == PM_DATA) good = (rd_data[7] == exp7);
        else                 good = have_prev && (rd_data[6] == prev6);
    end

    assign complete = (hits == HW'(TGT));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            have_prev <= 1'b0;
            prev6     <= 1'b0;
            hits      <= '0;
        end else if (rd_valid) begin
            have_prev <= 1'b1;
            prev6     <= rd_data[6];
            if (!good)         hits <= '0;
            else if (!complete) hits <= hits + 1'b1;
        end
    end

endmodule

// File: rtl/nws_timer.sv
module nws_timer
    import nws_pkg::*;
#(
    parameter int              W      = 25,
    parameter longint unsigned LIM_P  = 5000,
    parameter longint unsigned LIM_S  = 6250000,
    parameter longint unsigned LIM_C  = 25000000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  op_e  op,
    output logic expired
);

    logic [W-1:0] cnt;
    logic [W-1:0] lim;

    always_comb begin
        case (op)
            OP_PROG: lim = W'(LIM_P);
            OP_SECT: lim = W'(LIM_S);
            default: lim = W'(LIM_C);
        endcase
    end

    assign expired = (cnt >= lim);

    always_ff @(posedge clk) begin
        if (rst || clr)          cnt <= '0;
        else if (en && !expired) cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/nvm_write_seq.sv
module nvm_write_seq
    import nws_pkg::*;
#(
    parameter int ADDR_W        = 19,
    parameter int SECT_BYTES    = 128,
    parameter int CLK_NS        = 4,
    parameter int T_WP_NS       = 40,
    parameter int T_WPH_NS      = 30,
    parameter int T_OEH_NS      = 10,
    parameter int T_ACC_NS      = 55,
    parameter int CONFIRM_READS = 2,
    parameter int TO_SCALE      = 1,
    parameter int PROG_MAX_US   = 20,
    parameter int SECT_MAX_US   = 25000,
    parameter int CHIP_MAX_US   = 100000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    input  logic              req_poll_mode,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_dq_out,
    output logic              fl_dq_oe,
    input  logic [7:0]        fl_dq_in,
    output logic              fl_ce_n,
    output logic              fl_oe_n,
    output logic              fl_we_n
);

    localparam int WP_CYC  = int'(lmax(1, cdiv(64'(T_WP_NS),  64'(CLK_NS))));
    localparam int WPH_CYC = int'(lmax(1, cdiv(64'(T_WPH_NS), 64'(CLK_NS))));
    localparam int OEH_CYC = int'(lmax(1, cdiv(64'(T_OEH_NS), 64'(CLK_NS))));
    localparam int ACC_CYC = int'(lmax(1, cdiv(64'(T_ACC_NS), 64'(CLK_NS))));
    localparam longint unsigned LIM_P = cdiv(64'(PROG_MAX_US) * 1000 * 64'(TO_SCALE), 64'(CLK_NS));
    localparam longint unsigned LIM_S = cdiv(64'(SECT_MAX_US) * 1000 * 64'(TO_SCALE), 64'(CLK_NS));
    localparam longint unsigned LIM_C = cdiv(64'(CHIP_MAX_US) * 1000 * 64'(TO_SCALE), 64'(CLK_NS));
    localparam longint unsigned LIM_MAX = lmax(LIM_P, lmax(LIM_S, LIM_C));
    localparam int TMO_W = $clog2(LIM_MAX + 1);
    localparam logic [ADDR_W-1:0] SECT_MASK = ~ADDR_W'(SECT_BYTES - 1);

    typedef enum logic [1:0] { S_IDLE, S_CMD, S_POLL, S_FIN } st_e;

    st_e               st;
    op_e               op_q;
    pmode_e            mode_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;
    logic [2:0]        idx;
    logic              issued;
    logic              err_q;

    logic              accept;
    slot_t             slot;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic [ADDR_W-1:0] poll_addr;
    logic [2:0]        last_idx;
    logic              exp7;

    logic              bus_wr;
    logic              bus_rd;
    logic              bus_busy;
    logic              bus_done;
    logic [7:0]        bus_rdata;
    logic              poll_ok;
    logic              tmo;

    assign accept   = (st == S_IDLE) && req_valid && (req_op != 2'd0);
    assign slot     = cmd_slot(op_q, idx);
    assign last_idx = (op_q == OP_PROG) ? 3'd3 : 3'd5;
    assign exp7     = (op_q == OP_PROG) ? data_q[7] : 1'b1;

    always_comb begin
        case (slot.ak)
            AK_UNLOCK_A: wr_addr = ADDR_W'(UNLOCK_ADDR_A);
            AK_UNLOCK_B: wr_addr = ADDR_W'(UNLOCK_ADDR_B);
            AK_TARGET:   wr_addr = addr_q;
            default:     wr_addr = addr_q & SECT_MASK;
        endcase
        wr_data = slot.use_data ? data_q : slot.code;
        case (op_q)
            OP_PROG: poll_addr = addr_q;
            OP_SECT: poll_addr = addr_q & SECT_MASK;
            default: poll_addr = '0;
        endcase
    end

    assign bus_wr = (st == S_CMD)  && !issued;
    assign bus_rd = (st == S_POLL) && !issued && !poll_ok && !tmo;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            op_q   <= OP_NONE;
            mode_q <= PM_TOGGLE;
            addr_q <= '0;
            data_q <= '0;
            idx    <= '0;
            issued <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (accept) begin
                        op_q   <= op_e'(req_op);
                        mode_q <= pmode_e'(req_poll_mode);
                        addr_q <= req_addr;
                        data_q <= req_data;
                        idx    <= '0;
                        issued <= 1'b0;
                        err_q  <= 1'b0;
                        st     <= S_CMD;
                    end
                end
                S_CMD: begin
                    if (bus_wr) issued <= 1'b1;
                    if (bus_done) begin
                        issued <= 1'b0;
                        if (idx == last_idx) st <= S_POLL;
                        else                 idx <= idx + 1'b1;
                    end
                end
                S_POLL: begin
                    if (bus_rd)   issued <= 1'b1;
                    if (bus_done) issued <= 1'b0;
                    if (!issued) begin
                        if (poll_ok) begin
                            st <= S_FIN;
                        end else if (tmo) begin
                            err_q <= 1'b1;
                            st    <= S_FIN;
                        end
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign busy = (st == S_CMD) || (st == S_POLL);
    assign done = (st == S_FIN);
    assign err  = (st == S_FIN) && err_q;

    nws_bus #(
        .ADDR_W (ADDR_W),
        .WP_CYC (WP_CYC),
        .WPH_CYC(WPH_CYC),
        .OEH_CYC(OEH_CYC),
        .ACC_CYC(ACC_CYC)
    ) u_bus (
        .clk     (clk),
        .rst     (rst),
        .start_wr(bus_wr),
        .start_rd(bus_rd),
        .addr_in ((st == S_CMD) ? wr_addr : poll_addr),
        .data_in (wr_data),
        .dq_in   (fl_dq_in),
        .busy    (bus_busy),
        .done    (bus_done),
        .rdata   (bus_rdata),
        .f_addr  (fl_addr),
        .f_dout  (fl_dq_out),
        .f_doe   (fl_dq_oe),
        .f_ce_n  (fl_ce_n),
        .f_oe_n  (fl_oe_n),
        .f_we_n  (fl_we_n)
    );

    nws_poll #(
        .CONFIRM_READS(CONFIRM_READS)
    ) u_poll (
        .clk     (clk),
        .rst     (rst),
        .clr     (accept),
        .rd_valid(bus_done && (st == S_POLL)),
        .rd_data (bus_rdata),
        .mode    (mode_q),
        .exp7    (exp7),
        .complete(poll_ok)
    );

    nws_timer #(
        .W    (TMO_W),
        .LIM_P(LIM_P),
        .LIM_S(LIM_S),
        .LIM_C(LIM_C)
    ) u_tmo (
        .clk    (clk),
        .rst    (rst),
        .clr    (accept),
        .en     (st == S_POLL),
        .op     (op_q),
        .expired(tmo)
    );

    logic unused_bus_busy;
    assign unused_bus_busy = bus_busy;

endmodule

// File: rtl/nws_checker.sv
module nws_checker #(
    parameter int ADDR_W = 19,
    parameter int WP_CYC = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [ADDR_W-1:0] fl_addr,
    input logic [7:0]        fl_dq_out,
    input logic              fl_dq_oe,
    input logic              fl_ce_n,
    input logic              fl_oe_n,
    input logic              fl_we_n
);

    logic [15:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst)                       low_cnt <= '0;
        else if (!fl_we_n && low_cnt != 16'hFFFF) low_cnt <= low_cnt + 1'b1;
        else if (fl_we_n)              low_cnt <= '0;
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe));

    p_take_req_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && !done && req_valid && req_op != 2'd0) |=> busy);

    p_null_op_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_op == 2'd0) |=> !busy);

    p_hold_bus_r5: assert property (@(posedge clk) disable iff (rst)
        (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out) && fl_dq_oe));

    p_we_width_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(fl_we_n) |-> (low_cnt >= 16'(WP_CYC)));

    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(!fl_oe_n && !fl_we_n));

    p_no_contention_r6: assert property (@(posedge clk) disable iff (rst)
        fl_dq_oe |-> fl_oe_n);

    p_err_with_done_r9: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_busy_end_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

endmodule

bind nvm_write_seq nws_checker #(
    .ADDR_W(ADDR_W),
    .WP_CYC(WP_CYC)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_op   (req_op),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .fl_addr  (fl_addr),
    .fl_dq_out(fl_dq_out),
    .fl_dq_oe (fl_dq_oe),
    .fl_ce_n  (fl_ce_n),
    .fl_oe_n  (fl_oe_n),
    .fl_we_n  (fl_we_n)
);

// File: tb/nvm_write_seq_test.sv
module nvm_write_seq_test;

    localparam int ADDR_W   = 19;
    localparam int EXP_WP   = 10;   // ceil(40/4)
    localparam int EXP_WPH  = 8;    // ceil(30/4)
    localparam int EXP_OEH  = 3;    // ceil(10/4)
    localparam int PROG_LIM = 5000; // ceil(20*1000/4)

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [1:0]        req_op = 2'd0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [7:0]        req_data = '0;
    logic              req_poll_mode = 1'b0;
    logic              busy, done, err;
    logic [ADDR_W-1:0] fl_addr;
    logic [7:0]        fl_dq_out;
    logic              fl_dq_oe;
    logic [7:0]        fl_dq_in;
    logic              fl_ce_n, fl_oe_n, fl_we_n;

    always #2 clk = ~clk;

    nvm_write_seq uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_poll_mode(req_poll_mode),
        .busy(busy), .done(done), .err(err),
        .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
        .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    // device model
    bit        armed = 0;
    int        m_left = 0;
    int        m_reads = 0;
    int        m_glitch = 0;
    logic      m_tog = 1'b0;
    logic      m_exp7 = 1'b1;
    logic [7:0] m_final = 8'hFF;

    assign fl_dq_in = (m_left > 0) ?
        ((m_reads + 1 == m_glitch) ? {m_exp7, m_tog, 6'b0} : {~m_exp7, m_tog, 6'b0}) :
        m_final;

    always @(posedge fl_oe_n) begin
        if (armed) begin
            m_reads++;
            if (m_left > 0) begin
                m_left--;
                m_tog = ~m_tog;
            end
        end
    end

    logic [ADDR_W-1:0] w_addr [8];
    logic [7:0]        w_data [8];
    logic              w_doe  [8];
    int                wcount = 0;

    always @(posedge fl_we_n) begin
        if (armed && wcount < 8) begin
            w_addr[wcount] = fl_addr;
            w_data[wcount] = fl_dq_out;
            w_doe[wcount]  = fl_dq_oe;
            wcount++;
        end
    end

    // strobe timing monitor
    logic we_prev = 1'b1, oe_prev = 1'b1;
    int   low_run = 0, high_run = 0;
    bit   seen_rise = 0;
    int   min_low = 9999, min_high = 9999, min_oe_gap = 9999;

    always @(posedge clk) begin
        if (armed) begin
            if (!fl_we_n) begin
                if (we_prev && seen_rise && high_run < min_high) min_high = high_run;
                low_run++;
                high_run = 0;
            end else begin
                if (!we_prev) begin
                    if (low_run < min_low) min_low = low_run;
                    low_run = 0;
                    seen_rise = 1;
                end
                high_run++;
            end
            if (!fl_oe_n && oe_prev && seen_rise && high_run < min_oe_gap) min_oe_gap = high_run;
        end
        we_prev = fl_we_n;
        oe_prev = fl_oe_n;
    end

    int cyc_total = 0;
    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 150000 && !finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc_total);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // results of the last operation
    bit r_acc, r_gap, r_done, r_err, r_pulse;
    int r_cyc;

    task automatic do_op(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                         input logic [7:0] d, input logic mode, input int busy_reads,
                         input int glitch, input int maxcyc, input bit poke);
        m_final  = (op == 2'd1) ? d : 8'hFF;
        m_exp7   = m_final[7];
        m_left   = busy_reads;
        m_reads  = 0;
        m_glitch = glitch;
        m_tog    = 1'b0;
        wcount   = 0;
        min_low = 9999; min_high = 9999; min_oe_gap = 9999;
        seen_rise = 0; low_run = 0; high_run = 0;
        armed = 1;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d; req_poll_mode = mode;
        @(negedge clk);
        req_valid = 1'b0; req_op = 2'd0;
        r_acc = busy;
        r_gap = 0;
        r_cyc = 1;
        while (!done && r_cyc < maxcyc) begin
            @(negedge clk);
            r_cyc++;
            if (poke && r_cyc == 4) begin
                req_valid = 1'b1; req_op = 2'd3; req_addr = '0; req_data = 8'h00;
            end
            if (poke && r_cyc == 5) begin
                req_valid = 1'b0; req_op = 2'd0;
            end
            if (!done && !busy) r_gap = 1;
        end
        r_done = done;
        r_err  = err;
        @(negedge clk);
        r_pulse = !done;
        armed = 0;
        m_left = 0;
    endtask

    function automatic int toggle_reads(input int b, input logic final6);
        if (b > 0 && ((b - 1) % 2 == 1) == final6) return b + 3;
        return b + 4;
    endfunction

    task automatic check_common(input string tag);
        chk(r_acc, "R10", {tag, " busy after accept"}, r_acc, 1);
        chk(!r_gap, "R10", {tag, " busy held"}, r_gap, 0);
        chk(r_done, "R10", {tag, " done seen"}, r_done, 1);
        chk(r_pulse, "R10", {tag, " done one cycle"}, r_pulse, 1);
        chk(min_low >= EXP_WP, "R5", {tag, " we low width"}, min_low, EXP_WP);
        chk(min_high >= EXP_WPH, "R5", {tag, " we high gap"}, min_high, EXP_WPH);
        chk(min_oe_gap >= EXP_OEH, "R6", {tag, " oe gap after write"}, min_oe_gap, EXP_OEH);
        for (int i = 0; i < wcount; i++)
            chk(w_doe[i], "R5", {tag, " data driven at we rise"}, w_doe[i], 1);
    endtask

    task automatic check_write(input int i, input logic [ADDR_W-1:0] ea,
                               input logic [7:0] ed, input string rq);
        chk(w_addr[i] == ea, rq, $sformatf("write %0d addr", i), w_addr[i], ea);
        chk(w_data[i] == ed, rq, $sformatf("write %0d data", i), w_data[i], ed);
    endtask

    task automatic t_reset;
        chk(fl_ce_n && fl_oe_n && fl_we_n, "R1", "strobes high",
            {fl_ce_n, fl_oe_n, fl_we_n}, 3'b111);
        chk(!fl_dq_oe, "R1", "bus not driven", fl_dq_oe, 0);
        chk(!busy && !done && !err, "R1", "idle outputs", {busy, done, err}, 0);
    endtask

    task automatic t_null_op;
        armed = 1; wcount = 0;
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd0; req_addr = 19'h00123; req_data = 8'h11;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (30) @(negedge clk);
        chk(!busy, "R2", "op 0 not taken", busy, 0);
        chk(wcount == 0, "R2", "op 0 no writes", wcount, 0);
        chk(fl_we_n && fl_ce_n, "R1", "strobes idle after op 0", {fl_we_n, fl_ce_n}, 2'b11);
        armed = 0;
    endtask

    task automatic t_prog_toggle;
        logic [7:0] d = 8'h5A;
        do_op(2'd1, 19'h4ABCD, d, 1'b0, 3, 0, 3000, 0);
        check_common("prog toggle");
        chk(wcount == 4, "R3", "program write count", wcount, 4);
        check_write(0, 19'h00555, 8'hAA, "R3");
        check_write(1, 19'h002AA, 8'h55, "R3");
        check_write(2, 19'h00555, 8'hA0, "R3");
        check_write(3, 19'h4ABCD, d, "R3");
        chk(m_reads == toggle_reads(3, d[6]), "R7", "toggle read count",
            m_reads, toggle_reads(3, d[6]));
        chk(!r_err, "R9", "no error", r_err, 0);
    endtask

    task automatic t_prog_data_glitch;
        logic [7:0] d = 8'hC3;
        do_op(2'd1, 19'h00077, d, 1'b1, 5, 2, 3000, 0);
        check_common("prog data");
        check_write(3, 19'h00077, d, "R3");
        chk(m_reads == 8, "R8", "data poll read count with false hit", m_reads, 8);
        chk(!r_err, "R9", "no error", r_err, 0);
    endtask

    task automatic t_sector_toggle;
        do_op(2'd2, 19'h12345, 8'h00, 1'b0, 2, 0, 3000, 0);
        check_common("sector");
        chk(wcount == 6, "R4", "sector write count", wcount, 6);
        check_write(0, 19'h00555, 8'hAA, "R4");
        check_write(1, 19'h002AA, 8'h55, "R4");
        check_write(2, 19'h00555, 8'h80, "R4");
        check_write(3, 19'h00555, 8'hAA, "R4");
        check_write(4, 19'h002AA, 8'h55, "R4");
        check_write(5, 19'h12300, 8'h20, "R4");
        chk(m_reads == toggle_reads(2, 1'b1), "R7", "erase toggle read count",
            m_reads, toggle_reads(2, 1'b1));
    endtask

    task automatic t_chip_data;
        do_op(2'd3, 19'h7FFFF, 8'h00, 1'b1, 0, 0, 3000, 0);
        check_common("chip");
        chk(wcount == 6, "R4", "chip write count", wcount, 6);
        check_write(5, 19'h00555, 8'h10, "R4");
        chk(m_reads == 3, "R8", "erase data poll read count", m_reads, 3);
        chk(!r_err, "R9", "no error", r_err, 0);
    endtask

    task automatic t_req_while_busy;
        do_op(2'd1, 19'h01000, 8'h3C, 1'b1, 1, 0, 3000, 1);
        chk(wcount == 4, "R2", "request while busy adds no writes", wcount, 4);
        check_write(3, 19'h01000, 8'h3C, "R2");
        repeat (5) @(negedge clk);
        chk(!busy, "R2", "request while busy not queued", busy, 0);
    endtask

    task automatic t_timeout;
        do_op(2'd1, 19'h00010, 8'h01, 1'b1, 1000000, 0, 20000, 0);
        chk(r_done, "R9", "timeout ends operation", r_done, 1);
        chk(r_err, "R9", "timeout flags error", r_err, 1);
        chk(r_cyc >= PROG_LIM && r_cyc <= PROG_LIM + 200, "R9", "timeout cycle window",
            r_cyc, PROG_LIM);
        chk(r_pulse, "R10", "done one cycle after timeout", r_pulse, 1);
        @(negedge clk);
        chk(!err, "R9", "error clears with done", err, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_null_op();
        t_prog_toggle();
        t_prog_data_glitch();
        t_sector_toggle();
        t_chip_data();
        t_req_while_busy();
        t_timeout();
        t_reset();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule